// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block supervises software by counting ticks from a slow 32.768 kHz timebase. When software stops refreshing it in time, it either asks for a system reset or raises an interrupt request. The response depends on a mode bit. A four-bit timeout code sets the limit. Codes 0 to 7 give 512 ticks (about 15.6 ms) doubled once per step, up to 65536 ticks (2 s). Code 8 and above expire at once.

All control goes through one 8-bit control word. Writes to it are protected by an arm-then-write sequence, so a stray store cannot change the timeout, the mode or the enable. The status port reads back the control fields, the sticky timeout flag and the arm state. A dedicated kick input restarts the count without touching the configuration.

Top module: `wdt_guard`

## Requirements
- R1: After reset the status word reads 0x00: watchdog disabled, timeout code 0, reset-request mode, flag clear, not armed. `rst_req_o` and `irq_o` are low.
- R2: A write with bit 0 = 1 arms the block, and status bit 0 reads 1. A write on the very next clock cycle is accepted. It loads code from bits [7:4], interrupt mode from bit 3 and enable from bit 1. Status reads back the same field positions.
- R3: A write that does not directly follow an arming write changes no control field. An arm that is not followed by a write on the next cycle lapses.
- R4: With code c in 0..7 and the block enabled, expiry comes after exactly 512·2^c counted ticks with no refresh.
- R5: With a code of 8 or more (9..15 behave as 8), an enabled block expires on the first cycle in which the flag is clear.
- R6: In reset-request mode (bit 3 = 0), an expiry drives `rst_req_o` high for exactly one cycle, one cycle after the expiring tick.
- R7: In interrupt mode (bit 3 = 1), an expiry drives no reset request. `irq_o` stays high while the flag (status bit 2) is set.
- R8: The flag is set by every expiry. It stays set until an accepted write carries bit 2 = 0. An accepted write with bit 2 = 1 leaves it unchanged.
- R9: When disabled (bit 1 = 0), the block does not count and never expires.
- R10: A `kick_i` pulse, or an accepted write with bit 1 = 1, restarts the count from zero and keeps the timeout code.
- R11: Only cycles with `tick_i` high advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle strobe per 32.768 kHz period |
| kick_i | input | 1 | Refresh strobe, restarts the count |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| stat_o | output | 8 | {code[3:0], irq mode, flag, enable, armed} |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| irq_o | output | 1 | Watchdog interrupt request (level) |

## Verification
A miscounting timeout counter shows up as a reset pulse or interrupt at the wrong cycle. The tests measure that cycle against 512·2^c exactly, so an off-by-one is caught within one timeout period. A broken arm sequence shows on `stat_o` on the cycle after the offending write, since the control fields read back directly. A flag that clears or sets wrongly is seen on status bit 2 and on `irq_o` right after the write or expiry. A disable or kick that fails to reach the counter shows as a reset pulse where none, or a different one, was due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_IMM = 4'd8;

  // Control/status word layout, MSB first
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              irq_sel;
    logic              flag;
    logic              en;
    logic              arm;
  } wdt_word_t;

  function automatic logic is_immediate(input logic [CODE_W-1:0] code);
    return code >= CODE_IMM;
  endfunction

  // Last count value before expiry: 2^(base_log2+code) - 1
  function automatic logic [31:0] terminal_count(input int unsigned base_log2,
                                                 input logic [CODE_W-1:0] code);
    logic [31:0] one;
    one = 32'd1;
    return (one << (base_log2 + 32'(code[CODE_W-2:0]))) - 32'd1;
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wdt_word_t         wr_word,
  input  logic              expire,
  output logic [CODE_W-1:0] code,
  output logic              irq_sel,
  output logic              en,
  output logic              flag,
  output logic              arm,
  output logic              wr_accept,
  output logic              refresh
);
  logic [CODE_W-1:0] code_q;
  logic irq_q, en_q, flag_q, arm_q;

  assign wr_accept = wr_en & arm_q;
  assign refresh   = wr_accept & wr_word.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      irq_q  <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= wr_en & ~arm_q & wr_word.arm;
      if (wr_accept) begin
        code_q <= wr_word.code;
        irq_q  <= wr_word.irq_sel;
        en_q   <= wr_word.en;
      end
      if (expire)
        flag_q <= 1'b1;
      else if (wr_accept && !wr_word.flag)
        flag_q <= 1'b0;
    end
  end

  assign code    = code_q;
  assign irq_sel = irq_q;
  assign en      = en_q;
  assign flag    = flag_q;
  assign arm     = arm_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              flag,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);
  localparam int unsigned MAX_SHIFT = (1 << (CODE_W - 1)) - 1;
  localparam int unsigned CNT_W     = BASE_LOG2 + MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic imm, hit_regular, hit_imm;

  assign term        = CNT_W'(terminal_count(BASE_LOG2, code));
  assign imm         = is_immediate(code);
  assign hit_regular = en & ~imm & tick & (cnt_q >= term);
  assign hit_imm     = en & imm & ~flag;
  assign expire      = hit_regular | hit_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!en || clear || imm || hit_regular)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] stat_o,
  output logic       rst_req_o,
  output logic       irq_o
);
  wdt_word_t         wr_word;
  logic [CODE_W-1:0] code_w;
  logic irq_sel_w, en_w, flag_w, arm_w, wr_accept_w, refresh_w, expire_w;
  logic rst_req_q;

  assign wr_word = wdt_word_t'(wr_data_i);

  wdt_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_word   (wr_word),
    .expire    (expire_w),
    .code      (code_w),
    .irq_sel   (irq_sel_w),
    .en        (en_w),
    .flag      (flag_w),
    .arm       (arm_w),
    .wr_accept (wr_accept_w),
    .refresh   (refresh_w)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .en     (en_w),
    .flag   (flag_w),
    .clear  (kick_i | refresh_w),
    .code   (code_w),
    .expire (expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= expire_w & ~irq_sel_w;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = flag_w & irq_sel_w;
  assign stat_o    = {code_w, irq_sel_w, flag_w, en_w, arm_w};
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              arm,
  input logic [CODE_W-1:0] code,
  input logic              irq_sel,
  input logic              en,
  input logic              flag,
  input logic              expire,
  input logic              rst_req,
  input logic              irq
);
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && arm) |-> $stable({code, irq_sel, en})); // R2
  AST_FLAG_CLEAR_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && arm)); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_RST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag); // R8
  AST_EXPIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> en); // R9
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R7
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en_i),
  .arm     (arm_w),
  .code    (code_w),
  .irq_sel (irq_sel_w),
  .en      (en_w),
  .flag    (flag_w),
  .expire  (expire_w),
  .rst_req (rst_req_o),
  .irq     (irq_o)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       kick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] stat_o;
  logic       rst_req_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  wdt_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .stat_o(stat_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run too long (actual %0d cycles, expected < 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en_i = 1'b0; kick_i = 1'b0; tick_i = 1'b1; wr_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic unlock_write(input logic [7:0] d);
    wr(8'h01);
    wr(d);
    wr_end();
  endtask

  // cycles until rst_req_o (or irq_o when use_irq) is seen high
  task automatic wait_evt(input bit use_irq, output int n);
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(posedge clk); #1;
      n++;
      if (use_irq ? irq_o : rst_req_o) break;
    end
  endtask

  task automatic idle(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (rst_req_o) pulses++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", stat_o, 8'h00);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(8'h01);
    @(negedge clk);
    chk("R2 armed bit", stat_o[0], 1);
    wr_en_i = 1'b1; wr_data_i = 8'h22;
    @(posedge clk);
    wr_end();
    chk("R2 accepted word", stat_o, 8'h22);
  endtask

  task automatic t_locked();
    do_reset();
    wr(8'h22); wr_end();
    chk("R3 write without arm", stat_o, 8'h00);
    wr(8'h01); wr_end();
    @(negedge clk);
    wr(8'h22); wr_end();
    chk("R3 late write ignored", stat_o, 8'h00);
  endtask

  task automatic t_timeout(input int code);
    int n;
    do_reset();
    unlock_write({4'(code), 4'b0010});
    wait_evt(1'b0, n);
    chk($sformatf("R4 timeout code %0d", code), n, 512 << code);
    chk("R8 flag set", stat_o[2], 1);
    @(posedge clk); #1;
    chk("R6 pulse one cycle", rst_req_o, 0);
  endtask

  task automatic t_imm();
    int n, p;
    do_reset();
    unlock_write(8'h82);
    wait_evt(1'b0, n);
    chk("R5 code 8 immediate", n, 1);
    idle(20, p);
    chk("R5 no repeat while flag set", p, 0);
    unlock_write(8'h92);
    wait_evt(1'b0, n);
    chk("R5 code 9 acts as 8", n, 1);
  endtask

  task automatic t_irq();
    int p;
    do_reset();
    unlock_write(8'h0A);
    idle(600, p);
    chk("R7 no reset pulse", p, 0);
    chk("R7 irq high", irq_o, 1);
    chk("R7 flag set", stat_o[2], 1);
    unlock_write(8'h0A);
    chk("R7 irq drops with flag", irq_o, 0);
  endtask

  task automatic t_flag();
    int n;
    do_reset();
    unlock_write(8'h02);
    wait_evt(1'b0, n);
    unlock_write(8'h06);
    chk("R8 write 1 keeps flag", stat_o[2], 1);
    unlock_write(8'h02);
    chk("R8 write 0 clears flag", stat_o[2], 0);
  endtask

  task automatic t_disable();
    int p;
    do_reset();
    unlock_write(8'h02);
    idle(300, p);
    unlock_write(8'h00);
    idle(1000, p);
    chk("R9 disabled never expires", p, 0);
    chk("R9 status", stat_o, 8'h00);
  endtask

  task automatic t_kick();
    int n, p;
    do_reset();
    unlock_write(8'h02);
    idle(300, p);
    @(negedge clk); kick_i = 1'b1;
    @(posedge clk);
    @(negedge clk); kick_i = 1'b0;
    wait_evt(1'b0, n);
    chk("R10 kick restarts count", n, 512);
    chk("R10 code kept", stat_o[7:4], 0);
    do_reset();
    unlock_write(8'h12);
    idle(500, p);
    unlock_write(8'h12);
    wait_evt(1'b0, n);
    chk("R10 refresh write restarts count", n, 1024);
  endtask

  task automatic t_tick();
    int n, p;
    do_reset();
    tick_i = 1'b0;
    unlock_write(8'h02);
    idle(700, p);
    chk("R11 no ticks no expiry", p, 0);
    @(negedge clk); tick_i = 1'b1;
    wait_evt(1'b0, n);
    chk("R11 ticks counted", n, 512);
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_locked();
    t_timeout(0);
    t_timeout(1);
    t_timeout(2);
    t_imm();
    t_irq();
    t_flag();
    t_disable();
    t_kick();
    t_tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule